// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target device holds wedged. A single-cycle trigger starts it. Its cause input tells it why: the bus was not idle when a START was requested, or a transfer ran out of time. The sequencer first pulses a kill strobe to the host controller and holds the host disabled. It then takes the SCL and SDA pins away from the controller and plays a fixed release pattern. SCL is held high. After a short gap SDA is also held high. Later SDA is pulled low while SCL stays high, which forms a START condition, and after a long hold SDA goes high again, which forms a STOP condition. A final settling gap follows.

All gaps are counted in pulses of a one-microsecond tick input, not in clock cycles. When the pattern finishes, the pins go back to the controller. The host is re-enabled with its data-low timeout reset armed, a status-clear strobe wipes every clearable status bit, and `done` pulses for one cycle. The cause code accepted with the trigger is held on an output for the whole sequence.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset the sequencer is idle: `busy`, `done`, `host_kill`, `status_clr`, `scl_own` and `sda_own` are 0, `host_en` is 1 and `cause_q` is 0.
- R2: A `trig` sampled high while idle makes the next cycle the kill cycle: `busy`=1, `host_kill`=1, `host_en`=0. `host_en` then stays 0 until the final cycle of the sequence.
- R3: In the cycle after the kill cycle `scl_own` rises with `sda_own`=0. `sda_own` rises in the cycle after the clock edge that samples the 16th `us_tick` counted from that point. Ticks during the kill cycle are not counted.
- R4: SDA is held high (`sda_own`=1, `sda_lvl`=1) for 500 ticks. It is then driven low (`sda_lvl`=0) while `scl_own` stays 1, which forms a START condition.
- R5: SDA stays low for 1000 ticks, then returns high (`sda_lvl`=1), which forms a STOP condition. The pins stay owned for a further 500 ticks.
- R6: The final cycle of a sequence has `done`=1, `status_clr`=1, `host_en`=1 and both pins released. It lasts exactly one cycle and is followed by idle.
- R7: A `trig` that arrives while `busy`=1, including during the final cycle, is ignored. A new sequence starts only from a trigger sampled in idle.
- R8: `cause_q` takes the `cause` value (1 = bus not idle at START, 2 = transfer timeout) sampled with an accepted trigger. Changes on `cause` while busy do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| trig | input | 1 | Recovery request |
| cause | input | 2 | Reason code for the request (1 not idle, 2 timeout) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| host_kill | output | 1 | Strobe that aborts the host transaction |
| host_en | output | 1 | Host interface enable, low-timeout reset armed when 1 |
| status_clr | output | 1 | Strobe that clears all clearable host status bits |
| scl_own | output | 1 | Sequencer holds SCL high instead of the controller |
| sda_own | output | 1 | Sequencer drives SDA instead of the controller |
| sda_lvl | output | 1 | Level driven on SDA while `sda_own` is 1 |
| cause_q | output | 2 | Cause code of the accepted request |

## Verification
The bench drives the tick in four ways: absent, every fourth cycle, every cycle, and on an irregular pattern. A design that counted clock cycles instead of ticks, or that let a tick in the kill cycle count, would shift each SDA edge by at least one tick against the reference model. The trigger is held high through the final cycle, which catches a design that restarts from the done cycle and so cuts the required idle cycle. A second trigger with a different cause code mid-sequence catches a design that restarts or re-latches the cause. Off-by-one limits in the tick counter move the START or STOP edge and show up at once.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_KILL  = 3'd1,
    PH_SCL   = 3'd2,
    PH_SDA   = 3'd3,
    PH_START = 3'd4,
    PH_STOP  = 3'd5,
    PH_FIN   = 3'd6
  } rec_phase_t;
endpackage

// File: rtl/i2crec_timer.sv
module i2crec_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign expire = tick && !clr && (cnt_q == (limit - CW'(1)));

  always_comb begin
    cnt_d = cnt_q;
    if (clr || expire) cnt_d = '0;
    else if (tick)     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3/R4/R5: the tick count never reaches the limit of the current gap
  a_r3_cnt_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit);
endmodule

// File: rtl/i2crec_fsm.sv
module i2crec_fsm
  import i2crec_pkg::*;
#(
  parameter int CW      = 10,
  parameter int T_SCL   = 16,
  parameter int T_SDA   = 500,
  parameter int T_LOW   = 1000,
  parameter int T_TAIL  = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          expire,
  output rec_phase_t    phase,
  output logic          clr,
  output logic [CW-1:0] limit
);
  rec_phase_t ph_d;

  always_comb begin
    ph_d = phase;
    unique case (phase)
      PH_IDLE:  if (trig) ph_d = PH_KILL;
      PH_KILL:  ph_d = PH_SCL;
      PH_SCL:   if (expire) ph_d = PH_SDA;
      PH_SDA:   if (expire) ph_d = PH_START;
      PH_START: if (expire) ph_d = PH_STOP;
      PH_STOP:  if (expire) ph_d = PH_FIN;
      PH_FIN:   ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_comb begin
    clr   = 1'b0;
    limit = CW'(T_SCL);
    unique case (phase)
      PH_SCL:   limit = CW'(T_SCL);
      PH_SDA:   limit = CW'(T_SDA);
      PH_START: limit = CW'(T_LOW);
      PH_STOP:  limit = CW'(T_TAIL);
      default:  clr = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= ph_d;
  end

  // R7: a kill cycle is only ever entered from idle
  a_r7_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_KILL) |-> ($past(phase) == PH_IDLE));
  // R6: the final cycle is always followed by idle
  a_r6_fin_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FIN) |=> (phase == PH_IDLE));
endmodule

// File: rtl/i2crec_outdec.sv
module i2crec_outdec
  import i2crec_pkg::*;
(
  input  rec_phase_t phase,
  output logic       busy,
  output logic       done,
  output logic       host_kill,
  output logic       host_en,
  output logic       status_clr,
  output logic       scl_own,
  output logic       sda_own,
  output logic       sda_lvl
);
  always_comb begin
    busy       = (phase != PH_IDLE);
    done       = (phase == PH_FIN);
    status_clr = (phase == PH_FIN);
    host_kill  = (phase == PH_KILL);
    host_en    = (phase == PH_IDLE) || (phase == PH_FIN);
    scl_own    = (phase == PH_SCL) || (phase == PH_SDA) ||
                 (phase == PH_START) || (phase == PH_STOP);
    sda_own    = (phase == PH_SDA) || (phase == PH_START) || (phase == PH_STOP);
    sda_lvl    = (phase != PH_START);
  end
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
  import i2crec_pkg::*;
#(
  parameter int T_SCL  = 16,
  parameter int T_SDA  = 500,
  parameter int T_LOW  = 1000,
  parameter int T_TAIL = 500
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       trig,
  input  logic [1:0] cause,
  output logic       busy,
  output logic       done,
  output logic       host_kill,
  output logic       host_en,
  output logic       status_clr,
  output logic       scl_own,
  output logic       sda_own,
  output logic       sda_lvl,
  output logic [1:0] cause_q
);
  localparam int MAX_A = (T_SCL > T_SDA) ? T_SCL : T_SDA;
  localparam int MAX_B = (T_LOW > T_TAIL) ? T_LOW : T_TAIL;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAX_T + 1);

  logic [1:0]    rsync_q;
  logic          rst_s_n;
  rec_phase_t    phase;
  logic          clr, expire, cause_en;
  logic [CW-1:0] limit;
  logic [1:0]    cause_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  i2crec_fsm #(.CW(CW), .T_SCL(T_SCL), .T_SDA(T_SDA), .T_LOW(T_LOW),
               .T_TAIL(T_TAIL)) u_fsm (
    .clk(clk), .rst_n(rst_s_n), .trig(trig), .expire(expire),
    .phase(phase), .clr(clr), .limit(limit));

  i2crec_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_s_n), .clr(clr), .tick(us_tick),
    .limit(limit), .expire(expire));

  i2crec_outdec u_dec (
    .phase(phase), .busy(busy), .done(done), .host_kill(host_kill),
    .host_en(host_en), .status_clr(status_clr), .scl_own(scl_own),
    .sda_own(sda_own), .sda_lvl(sda_lvl));

  assign cause_en = (phase == PH_IDLE) && trig;

  always_comb begin
    cause_d = cause_q;
    if (cause_en) cause_d = cause;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) cause_q <= 2'b00;
    else          cause_q <= cause_d;
  end

  // R4: SDA falls (START) only while SCL is held high
  a_r4_start_under_scl: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sda_own && $fell(sda_lvl)) |-> scl_own);
  // R3: SDA is taken only after SCL is already held
  a_r3_sda_after_scl: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(sda_own) |-> $past(scl_own));
  // R6: done lasts one cycle and comes with release and re-enable
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> !done);
  a_r6_done_release: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |-> (host_en && status_clr && !scl_own && !sda_own));
  // R2: after the kill strobe the host stays disabled while pins are driven
  a_r2_kill_then_off: assert property (@(posedge clk) disable iff (!rst_s_n)
    host_kill |=> (!host_en && scl_own));
  // R8: cause code is frozen for the body of a sequence
  a_r8_cause_frozen: assert property (@(posedge clk) disable iff (!rst_s_n)
    (busy && !host_kill) |-> $stable(cause_q));
endmodule

// File: tb/sim_i2c_bus_recover.sv
module sim_i2c_bus_recover;
  logic clk = 1'b0;
  logic rst_n, us_tick, trig;
  logic [1:0] cause;
  logic busy, done, host_kill, host_en, status_clr, scl_own, sda_own, sda_lvl;
  logic [1:0] cause_q;

  int checks = 0, failures = 0;
  int tick_mode = 0;
  int cyc = 0;
  bit finished = 0;

  // reference model state
  int mph = 0;   // 0 idle, 1 kill, 2 run, 3 final
  int tk  = 0;   // ticks counted since SCL was taken
  int ecause = 0;
  int rs_cnt = 0; // cycles since reset release (for the internal sync)

  always #5 clk = ~clk;

  i2c_bus_recover u0 (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .trig(trig), .cause(cause),
    .busy(busy), .done(done), .host_kill(host_kill), .host_en(host_en),
    .status_clr(status_clr), .scl_own(scl_own), .sda_own(sda_own),
    .sda_lvl(sda_lvl), .cause_q(cause_q));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // model update on the active edge; inputs are stable here
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mph = 0; tk = 0; ecause = 0; rs_cnt = 0;
    end else if (rs_cnt < 2) begin
      rs_cnt++;
    end else begin
      case (mph)
        0: if (trig) begin mph = 1; ecause = int'(cause); end
        1: begin mph = 2; tk = 0; end
        2: if (us_tick) begin
             tk++;
             if (tk == 2016) mph = 3;
           end
        default: mph = 0;
      endcase
    end
  end

  // tick generator and comparison away from the edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      automatic int esda_own = (mph == 2 && tk >= 16) ? 1 : 0;
      chk("R2 busy", int'(busy), (mph != 0) ? 1 : 0);
      chk("R2 host_kill", int'(host_kill), (mph == 1) ? 1 : 0);
      chk("R2 host_en", int'(host_en), (mph == 0 || mph == 3) ? 1 : 0);
      chk("R6 done", int'(done), (mph == 3) ? 1 : 0);
      chk("R6 status_clr", int'(status_clr), (mph == 3) ? 1 : 0);
      chk("R3 scl_own", int'(scl_own), (mph == 2) ? 1 : 0);
      chk("R3 sda_own", int'(sda_own), esda_own);
      if (esda_own == 1)
        chk("R4 R5 sda_lvl", int'(sda_lvl), (tk >= 516 && tk < 1516) ? 0 : 1);
      chk("R8 cause_q", int'(cause_q), ecause);
      if (mph == 0 && rs_cnt >= 2)
        chk("R1 idle pins", int'(scl_own) + int'(sda_own), 0);
    end
    case (tick_mode)
      1: us_tick = (cyc % 4 == 0);
      2: us_tick = 1'b1;
      3: us_tick = (cyc % 3 == 0) || (cyc % 7 == 0);
      default: us_tick = 1'b0;
    endcase
  end

  task automatic wait_done();
    @(negedge clk);
    while (!done && !finished) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; trig = 1'b0; cause = 2'd0; us_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 host_en", int'(host_en), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 cause_q", int'(cause_q), 0);

    // sequence A: tick every fourth cycle, cause 1, a stray trigger mid-way (R7, R8)
    tick_mode = 1;
    cause = 2'd1; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk("R2 kill cycle", int'(host_kill), 1);
    repeat (300) @(negedge clk);
    cause = 2'd2; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk("R7 still running", int'(busy), 1);
    chk("R8 cause held", int'(cause_q), 1);
    wait_done();
    chk("R6 done seen", int'(done), 1);
    @(negedge clk);
    chk("R6 idle after done", int'(busy), 0);
    repeat (10) @(negedge clk);

    // sequence B: tick every cycle, trigger held across the final cycle (R7)
    tick_mode = 2;
    cause = 2'd2; trig = 1'b1;
    wait_done();
    @(negedge clk);
    chk("R7 final cycle trigger ignored", int'(busy), 0);
    @(negedge clk);
    trig = 1'b0;
    chk("R2 retrigger from idle", int'(host_kill), 1);
    chk("R8 cause 2", int'(cause_q), 2);
    wait_done();
    repeat (5) @(negedge clk);

    // sequence C: irregular ticks, cause 1
    tick_mode = 3;
    cause = 2'd1; trig = 1'b1;
    @(negedge clk);
    trig = 1'b0; cause = 2'd3;
    wait_done();
    repeat (5) @(negedge clk);

    // no ticks: sequence must stall with SCL held (R3)
    tick_mode = 0;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (50) @(negedge clk);
    chk("R3 stalled without ticks", int'(scl_own), 1);
    chk("R3 sda not taken", int'(sda_own), 0);
    tick_mode = 2;
    wait_done();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule